// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt events from a small microcontroller's sources and turns them into one request line and a vector address for the CPU. There are six sources at the default size: timer 0, external edge input 1, external edge input 2, a port-change input, timer 1, and one generic peripheral slot. The peripheral group can be widened with a parameter. Each source owns a sticky event flag, a mask bit and a level bit. A small register port lets software read these bits, set them, and clear flags.

A mode bit chooses between two schemes. In single-level compatibility mode, every accepted source vectors to 0x0008. In that mode the second gating bit acts as an enable for the peripheral group only. In two-level mode, sources marked high vector to 0x0008 and sources marked low vector to 0x0018. In that mode the second gating bit enables the low level. The first gating bit is the global enable. When it is clear, nothing reaches the CPU in either mode.

When the CPU accepts an interrupt, the controller clears the gating bit of the level being taken. A return pulse sets that bit again.

Top module: `irq_ctrl`

## Requirements
- R1: After synchronous reset, every flag, mask, level and control bit reads 0, and the request output is low.
- R2: A one-cycle event pulse on `evt[i]` sets flag i, even when source i is masked. The flag stays set until software writes a 1 to bit i at address 0 (flag register). If an event and a clear hit the same bit in the same cycle, the event wins.
- R3: While control bit 0 (global gate) is 0, `irq_req` stays low in both modes, whatever the flags, masks, levels and control bit 1.
- R4: In compatibility mode (control bit 2 = 0) with the global gate set, an unmasked pending flag among bits 0 to 3 drives `irq_req` high with `irq_vec` = 0x0008.
- R5: In compatibility mode, sources at bit 4 and above (the peripheral group) raise a request only when control bit 1 (second gate) is also set.
- R6: In two-level mode (control bit 2 = 1), an unmasked pending source whose level bit (address 2) is 1 raises a request with vector 0x0008 when only the global gate is set.
- R7: In two-level mode, a pending source whose level bit is 0 raises a request with vector 0x0018. It does so only when both the global gate and the second gate are set.
- R8: When high-level and low-level sources are pending together, the output carries vector 0x0008. The low vector appears once the high sources are gone.
- R9: An `irq_ack` pulse during an active request clears the global gate if the vector is 0x0008, and clears the second gate if the vector is 0x0018. The change is visible one cycle later, and the request drops on the following edge.
- R10: An `irq_ret` pulse sets the second gate when `ret_low` = 1, and sets the global gate when `ret_low` = 0.
- R11: `irq_req` rises on the clock edge after the edge that set the flag. It falls on the edge after the edge that cleared the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | W | One-cycle event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 flags (write 1 to clear), 1 masks, 2 levels, 3 control |
| wr_data | input | W | Write data |
| rd_data | output | W | Read data of the selected register; control reads as {mode, second gate, global gate} in bits 2..0 |
| irq_ack | input | 1 | CPU accepts the current request |
| irq_ret | input | 1 | CPU returns from an interrupt |
| ret_low | input | 1 | Level of the return: 1 low, 0 high or compatibility |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 16 | Vector address of the request |

## Verification
The hardest state to reach is the nesting case in two-level mode. A low-level request is taken and its gate cleared, then a return restores that gate. After that, a high-level event must override the pending low source, be taken in turn, and have only the global gate cleared.

The stimulus builds this state step by step through the ports. It arms both gates, leaves a low-level flag pending, and acknowledges it. It returns with `ret_low` high, then fires a high-level event on top. It reads the control register back after each acknowledge and each return.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NCORE = 4;

    localparam logic [15:0] VEC_HI = 16'h0008;
    localparam logic [15:0] VEC_LO = 16'h0018;

    typedef enum logic [1:0] {
        REG_FLAG = 2'd0,
        REG_MASK = 2'd1,
        REG_LVL  = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic prio_mode;
        logic gate_lo;
        logic gate_hi;
    } gate_t;

    function automatic logic [15:0] pick_vec(input logic hi, input logic lo);
        if (hi)
            return VEC_HI;
        else if (lo)
            return VEC_LO;
        else
            return 16'h0000;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    input  logic         mask_we,
    input  logic         lvl_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flag,
    output logic [W-1:0] mask,
    output logic [W-1:0] lvl
);

    for (genvar i = 0; i < W; i++) begin : g_src
        logic f_q, m_q, l_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                f_q <= 1'b0;
                m_q <= 1'b0;
                l_q <= 1'b0;
            end else begin
                if (evt[i])
                    f_q <= 1'b1;
                else if (clr[i])
                    f_q <= 1'b0;
                if (mask_we)
                    m_q <= wdata[i];
                if (lvl_we)
                    l_q <= wdata[i];
            end
        end

        assign flag[i] = f_q;
        assign mask[i] = m_q;
        assign lvl[i]  = l_q;
    end

endmodule

// File: rtl/irq_gate_ctl.sv
module irq_gate_ctl
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic [2:0] wdata,
    input  logic       ack_hi,
    input  logic       ack_lo,
    input  logic       ret_hi,
    input  logic       ret_lo,
    output gate_t      gate
);

    gate_t g_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= '0;
        end else begin
            gate_t nxt;
            nxt = g_q;
            if (ctrl_we)
                nxt = gate_t'(wdata);
            if (ack_hi)
                nxt.gate_hi = 1'b0;
            if (ack_lo)
                nxt.gate_lo = 1'b0;
            if (ret_hi)
                nxt.gate_hi = 1'b1;
            if (ret_lo)
                nxt.gate_lo = 1'b1;
            g_q <= nxt;
        end
    end

    assign gate = g_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] flag,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] lvl,
    input  gate_t        gate,
    output logic         req,
    output logic         low,
    output logic [15:0]  vec
);

    logic [W-1:0] pgrp;
    logic [W-1:0] act;
    logic         core_any, per_any, hi_any, lo_any;
    logic         hi_fire, lo_fire;

    for (genvar i = 0; i < W; i++) begin : g_grp
        assign pgrp[i] = (i >= NCORE);
    end

    assign act = flag & mask;

    always_comb begin
        core_any = |(act & ~pgrp);
        per_any  = |(act & pgrp);
        hi_any   = |(act & lvl);
        lo_any   = |(act & ~lvl);
        if (gate.prio_mode) begin
            hi_fire = gate.gate_hi & hi_any;
            lo_fire = gate.gate_hi & gate.gate_lo & lo_any & ~hi_fire;
        end else begin
            hi_fire = gate.gate_hi & (core_any | (gate.gate_lo & per_any));
            lo_fire = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
            low <= 1'b0;
            vec <= 16'h0000;
        end else begin
            req <= hi_fire | lo_fire;
            low <= lo_fire;
            vec <= pick_vec(hi_fire, lo_fire);
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int NPERIPH = 2,
    localparam int W = NCORE + NPERIPH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         irq_ack,
    input  logic         irq_ret,
    input  logic         ret_low,
    output logic         irq_req,
    output logic [15:0]  irq_vec
);

    logic [W-1:0] flag_q, mask_q, lvl_q, clr;
    gate_t        gate_q;
    logic         irq_low;
    logic         ack_fire;
    reg_sel_e     sel;

    assign sel      = reg_sel_e'(addr);
    assign clr      = (wr_en && sel == REG_FLAG) ? wr_data : '0;
    assign ack_fire = irq_ack & irq_req;

    irq_flag_bank #(.W(W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .clr     (clr),
        .mask_we (wr_en && sel == REG_MASK),
        .lvl_we  (wr_en && sel == REG_LVL),
        .wdata   (wr_data),
        .flag    (flag_q),
        .mask    (mask_q),
        .lvl     (lvl_q)
    );

    irq_gate_ctl u_gate (
        .clk     (clk),
        .rst     (rst),
        .ctrl_we (wr_en && sel == REG_CTRL),
        .wdata   (wr_data[2:0]),
        .ack_hi  (ack_fire & ~irq_low),
        .ack_lo  (ack_fire & irq_low),
        .ret_hi  (irq_ret & ~ret_low),
        .ret_lo  (irq_ret & ret_low),
        .gate    (gate_q)
    );

    irq_arbiter #(.W(W)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .flag (flag_q),
        .mask (mask_q),
        .lvl  (lvl_q),
        .gate (gate_q),
        .req  (irq_req),
        .low  (irq_low),
        .vec  (irq_vec)
    );

    always_comb begin
        case (sel)
            REG_FLAG: rd_data = flag_q;
            REG_MASK: rd_data = mask_q;
            REG_LVL:  rd_data = lvl_q;
            default:  rd_data = W'(gate_q);
        endcase
    end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_pkg::*;
#(
    parameter int W = 6
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] flag,
    input logic [W-1:0] mask,
    input logic [W-1:0] lvl,
    input logic         gate_hi,
    input logic         gate_lo,
    input logic         prio_mode,
    input logic         wr_en,
    input logic         irq_ack,
    input logic         irq_ret,
    input logic         ret_low,
    input logic         irq_req,
    input logic [15:0]  irq_vec
);

    logic [W-1:0] act;
    assign act = flag & mask;

    AST_GLOBAL_BLOCK: assert property (@(posedge clk) disable iff (rst)
        !gate_hi |=> !irq_req); // R3

    AST_NO_FLAG_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !(|act) |=> !irq_req); // R11

    AST_PERIPH_GATED: assert property (@(posedge clk) disable iff (rst)
        (!prio_mode && !gate_lo && !(|act[NCORE-1:0])) |=> !irq_req); // R5

    AST_COMPAT_VEC: assert property (@(posedge clk) disable iff (rst)
        !prio_mode |=> (!irq_req || irq_vec == VEC_HI)); // R4

    AST_LOW_NEEDS_GATE: assert property (@(posedge clk) disable iff (rst)
        (!prio_mode || !gate_lo) |=> !(irq_req && irq_vec == VEC_LO)); // R7

    AST_HIGH_WINS: assert property (@(posedge clk) disable iff (rst)
        (prio_mode && gate_hi && |(act & lvl)) |=> (irq_req && irq_vec == VEC_HI)); // R8

    AST_ACK_HI_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && irq_vec == VEC_HI && !irq_ret && !wr_en) |=> !gate_hi); // R9

    AST_ACK_LO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && irq_vec == VEC_LO && !irq_ret && !wr_en) |=> !gate_lo); // R9

    AST_RET_SETS: assert property (@(posedge clk) disable iff (rst)
        irq_ret |=> (ret_low ? gate_lo : gate_hi)); // R10

    AST_REQ_CLEAN_RESET: assert property (@(posedge clk)
        rst |=> !irq_req); // R1

endmodule

bind irq_ctrl irq_ctrl_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flag      (flag_q),
    .mask      (mask_q),
    .lvl       (lvl_q),
    .gate_hi   (gate_q.gate_hi),
    .gate_lo   (gate_q.gate_lo),
    .prio_mode (gate_q.prio_mode),
    .wr_en     (wr_en),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .ret_low   (ret_low),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec)
);

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;

    localparam int W = 6;
    localparam logic [15:0] HI = 16'h0008;
    localparam logic [15:0] LO = 16'h0018;
    localparam logic [1:0] A_FLAG = 2'd0, A_MASK = 2'd1, A_LVL = 2'd2, A_CTRL = 2'd3;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] evt;
    logic         wr_en;
    logic [1:0]   addr;
    logic [W-1:0] wr_data;
    logic [W-1:0] rd_data;
    logic         irq_ack, irq_ret, ret_low;
    logic         irq_req;
    logic [15:0]  irq_vec;

    always #2 clk = ~clk;

    irq_ctrl u0 (
        .clk(clk), .rst(rst), .evt(evt), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .ret_low(ret_low), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    typedef struct packed {
        int           cyc;
        logic         is_rd;
        logic         req;
        logic [15:0]  vec;
        logic [W-1:0] rd;
        logic [23:0]  tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares every expectation due in the current cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == cyc) begin
                n_run++;
                if (q[i].is_rd) begin
                    if (rd_data !== q[i].rd) begin
                        n_fail++;
                        $display("FAIL %s: rd_data=%h expected %h (cycle %0d)",
                                 q[i].tag, rd_data, q[i].rd, cyc);
                    end
                end else if (irq_req !== q[i].req ||
                             (q[i].req && irq_vec !== q[i].vec)) begin
                    n_fail++;
                    $display("FAIL %s: req=%b vec=%h expected req=%b vec=%h (cycle %0d)",
                             q[i].tag, irq_req, irq_vec, q[i].req, q[i].vec, cyc);
                end
                q.delete(i);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic exp_out(int d, logic r, logic [15:0] v, logic [23:0] t);
        q.push_back('{cyc: cyc + d, is_rd: 1'b0, req: r, vec: v, rd: '0, tag: t});
    endtask

    task automatic chk_rd(logic [1:0] a, logic [W-1:0] v, logic [23:0] t);
        addr = a;
        q.push_back('{cyc: cyc, is_rd: 1'b1, req: 1'b0, vec: 16'h0, rd: v, tag: t});
        step();
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(logic [W-1:0] m);
        evt = m;
        step();
        evt = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    task automatic ret(logic lo);
        irq_ret = 1'b1; ret_low = lo;
        step();
        irq_ret = 1'b0; ret_low = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; evt = '0; wr_en = 1'b0; addr = '0; wr_data = '0;
        irq_ack = 1'b0; irq_ret = 1'b0; ret_low = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        exp_out(0, 1'b0, 16'h0, "R1");
        chk_rd(A_FLAG, '0, "R1");
        chk_rd(A_MASK, '0, "R1");
        chk_rd(A_LVL,  '0, "R1");
        chk_rd(A_CTRL, '0, "R1");

        // R2: masked flag sets, sticks, clears by write-one
        pulse(6'b000010);
        chk_rd(A_FLAG, 6'b000010, "R2");
        step();
        chk_rd(A_FLAG, 6'b000010, "R2");
        wr(A_FLAG, 6'b000010);
        chk_rd(A_FLAG, '0, "R2");
        // R2: event wins over clear in the same cycle
        evt = 6'b000100; addr = A_FLAG; wr_data = 6'b000100; wr_en = 1'b1;
        step();
        evt = '0; wr_en = 1'b0; wr_data = '0;
        chk_rd(A_FLAG, 6'b000100, "R2");
        wr(A_FLAG, '1);

        // R3: global gate clear blocks all
        wr(A_MASK, '1);
        pulse(6'b000001);
        exp_out(1, 1'b0, 16'h0, "R3");
        exp_out(2, 1'b0, 16'h0, "R3");
        step(); step(); step();
        wr(A_CTRL, 6'b000110);
        pulse(6'b000010);
        exp_out(1, 1'b0, 16'h0, "R3");
        exp_out(2, 1'b0, 16'h0, "R3");
        step(); step(); step();
        wr(A_FLAG, '1);

        // R4 / R11: compatibility, core source, timing
        wr(A_CTRL, 6'b000001);
        pulse(6'b001000);
        exp_out(0, 1'b0, 16'h0, "R11");
        exp_out(1, 1'b1, HI, "R4");
        step(); step();
        wr(A_FLAG, 6'b001000);
        exp_out(0, 1'b1, HI, "R11");
        exp_out(1, 1'b0, 16'h0, "R11");
        step(); step();

        // R5: peripheral group needs second gate
        pulse(6'b010000);
        exp_out(1, 1'b0, 16'h0, "R5");
        exp_out(2, 1'b0, 16'h0, "R5");
        step(); step(); step();
        wr(A_CTRL, 6'b000011);
        exp_out(1, 1'b1, HI, "R5");
        step(); step();
        wr(A_FLAG, 6'b010000);
        exp_out(1, 1'b0, 16'h0, "R5");
        step(); step();

        // R6: two-level mode, high source, global gate only
        wr(A_LVL, 6'b000001);
        chk_rd(A_LVL, 6'b000001, "R6");
        wr(A_CTRL, 6'b000101);
        pulse(6'b000001);
        exp_out(1, 1'b1, HI, "R6");
        step(); step();
        wr(A_FLAG, 6'b000001);
        step(); step();

        // R7: low source needs both gates, vectors to 0x0018
        pulse(6'b000010);
        exp_out(1, 1'b0, 16'h0, "R7");
        step(); step();
        wr(A_CTRL, 6'b000111);
        exp_out(1, 1'b1, LO, "R7");
        step(); step();

        // R8: high wins while low pending
        pulse(6'b000001);
        exp_out(1, 1'b1, HI, "R8");
        step(); step();
        wr(A_FLAG, 6'b000001);
        exp_out(1, 1'b1, LO, "R8");
        step(); step();

        // R9 / R10: acknowledge low level, then return
        ack();
        exp_out(0, 1'b1, LO, "R9");
        exp_out(1, 1'b0, 16'h0, "R9");
        chk_rd(A_CTRL, 6'b000101, "R9");
        step();
        ret(1'b1);
        exp_out(1, 1'b1, LO, "R10");
        chk_rd(A_CTRL, 6'b000111, "R10");
        step();

        // R8 / R9 / R10: high event over the pending low one
        pulse(6'b000001);
        exp_out(1, 1'b1, HI, "R8");
        step(); step();
        ack();
        exp_out(1, 1'b0, 16'h0, "R9");
        chk_rd(A_CTRL, 6'b000110, "R9");
        step();
        ret(1'b0);
        exp_out(1, 1'b1, HI, "R10");
        chk_rd(A_CTRL, 6'b000111, "R10");
        step(); step();

        while (q.size() != 0 && q[0].cyc >= cyc) step();
        if (q.size() != 0) begin
            n_fail += q.size();
            $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule